// File: doc/BRIEF.md
# Full-Chip Erase Block Sequencer

This block runs a whole-array erase on a flash array of 39 erase blocks. After a confirmed erase command it is given a one-cycle start pulse. At that moment it captures which blocks may be erased. It then asks an external per-block erase engine to erase those blocks one at a time, starting with the lowest-address block. It finishes when the list is exhausted, when the engine reports a failure, or when the block detects at start that it has nothing it may do.

The array layout is fixed by three parameters and indexed from the lowest address upward:

- Indices 0 and 1 are the two small boot blocks.
- Indices 2 to 7 are the six small parameter blocks.
- Indices 8 to 38 are the thirty-one large main blocks.

A block is erasable when its lock bit is clear. A boot block additionally needs the write-protect pin to be high. Write-protect has no effect on parameter or main blocks. Outcome flags are reported in status-register bit positions.

The controller is a four-state machine:

- **IDLE**: nothing running. The transition *launch* (start pulse) captures the erasable mask and the supply level, and moves to CHECK.
- **CHECK**: one cycle of screening.
  - *supply_abort*: the supply was low, so return to IDLE.
  - *protect_abort*: no block is erasable, so return to IDLE.
  - *proceed*: go to SEEK.
- **SEEK**: picks the lowest pending block.
  - *issue*: a pending block exists, so go to ERASE.
  - *finish*: none is left, so return to IDLE.
- **ERASE**: holds the request to the engine.
  - *next*: the engine reports done, so return to SEEK.
  - *fail_abort*: the engine reports a failure, so return to IDLE.

The synchronous reset forces IDLE from any state.

Top module: `chip_wipe_seq`

## Requirements
- R1: While or after `rst` is high, `busy_o` and `eng_req_o` are 0 and `flags_o` is 8'h00.
- R2: A `start_i` pulse seen in idle makes `busy_o` 1 from the next cycle. `busy_o` stays 1 until the sequence ends, then returns to 0.
- R3: Erasable blocks are requested in strictly ascending index order, each exactly once. Indices 0–1 are boot, 2–7 are parameter and 8–38 are main. A run with no error ends with `flags_o` = 8'h00.
- R4: A block whose `lock_i` bit is 1 is never requested.
- R5: When `wp_n_i` is 0, blocks 0 and 1 are never requested, whatever their lock bits. `wp_n_i` does not change which of blocks 2–38 are requested.
- R6: `eng_req_o` with `eng_blk_o` stays asserted and stable until `eng_done_i` or `eng_fail_i`. It is then low for at least one cycle, so at most one request is outstanding.
- R7: When `eng_fail_i` is 1 during a request, no further block is requested, `busy_o` falls, and `flags_o` = 8'h20 (bit 5, erase error).
- R8: If no block is erasable at start, no request is made and `flags_o` = 8'h22 (bit 1 protect, bit 5 erase error).
- R9: If `supply_ok_i` is 0 at start, no request is made and `flags_o` = 8'h28 (bit 3 supply, bit 5 erase error). This check takes precedence over R8.
- R10: `suspend_i` has no effect; the request sequence and final flags are unchanged by it.
- R11: `rst` high during a run ends it: `busy_o` and `eng_req_o` are 0 in the next cycle.
- R12: A `start_i` pulse while busy is ignored, and the run continues unchanged.
- R13: The erasable mask and supply level are captured at the start pulse, and `flags_o` is cleared to 8'h00 at each accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle launch pulse |
| lock_i | input | 39 | Per-block lock bits, index 0 = lowest address |
| wp_n_i | input | 1 | Write-protect level; 0 protects boot blocks |
| supply_ok_i | input | 1 | Program supply above lockout |
| suspend_i | input | 1 | Suspend request (ignored) |
| eng_req_o | output | 1 | Erase request to engine |
| eng_blk_o | output | 6 | Index of block to erase |
| eng_done_i | input | 1 | Engine finished the block successfully |
| eng_fail_i | input | 1 | Engine reports erase failure |
| busy_o | output | 1 | Sequence in progress |
| flags_o | output | 8 | Status flags: bit 5 erase error, bit 3 supply, bit 1 protect |

## Verification
The main function is tried with these patterns:

- A fully unlocked array, with write-protect high and then low. This separates ordering from boot handling.
- An alternating lock pattern. This shows skipping works across the boot, parameter and main boundaries.
- A single unlocked block at the top index, and an array where only the boot blocks are unlocked but protected. These separate a one-block run from the protect error.

Failure injected at the first block and at a middle block shows that termination cuts the rest of the queue. A low supply combined with an all-locked array shows which error wins. Suspend held high, a second start mid-run, and a reset mid-run each show that the request stream is either unchanged or cleanly cut.

// File: rtl/wipe_pkg.sv
package wipe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_SEEK,
        ST_ERASE
    } wipe_state_e;

    localparam int FLAG_W       = 8;
    localparam int FLAG_PROTECT = 1;
    localparam int FLAG_SUPPLY  = 3;
    localparam int FLAG_ERASE   = 5;

endpackage

// File: rtl/wipe_mask.sv
module wipe_mask #(
    parameter int NBOOT = 2,
    parameter int NBLK  = 39
) (
    input  logic [NBLK-1:0] lock_i,
    input  logic            wp_n_i,
    output logic [NBLK-1:0] mask_o
);

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        if (g < NBOOT) begin : g_boot
            // boot block: needs clear lock bit and write-protect released
            assign mask_o[g] = ~lock_i[g] & wp_n_i;
        end else begin : g_other
            assign mask_o[g] = ~lock_i[g];
        end
    end

endmodule

// File: rtl/wipe_scan.sv
module wipe_scan #(
    parameter int NBLK = 39,
    parameter int IDXW = 6
) (
    input  logic [NBLK-1:0] pend_i,
    output logic [IDXW-1:0] idx_o,
    output logic            hit_o
);

    // lowest set index wins: walk downward so the last match kept is the lowest
    always_comb begin
        idx_o = '0;
        hit_o = 1'b0;
        for (int i = NBLK - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IDXW'(i);
                hit_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wipe_fsm.sv
module wipe_fsm
    import wipe_pkg::*;
#(
    parameter int NBLK = 39,
    parameter int IDXW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              supply_ok_i,
    input  logic              suspend_i,
    input  logic [NBLK-1:0]   mask_i,
    input  logic [IDXW-1:0]   scan_idx_i,
    input  logic              scan_hit_i,
    output logic [NBLK-1:0]   pend_o,
    input  logic              eng_done_i,
    input  logic              eng_fail_i,
    output logic              eng_req_o,
    output logic [IDXW-1:0]   eng_blk_o,
    output logic              busy_o,
    output logic [FLAG_W-1:0] flags_o
);

    wipe_state_e     state_q, state_d;
    logic [NBLK-1:0] pend_q;
    logic [IDXW-1:0] cur_q;
    logic            sup_q;
    logic            none_left;

    assign none_left = (pend_q == '0);
    assign pend_o    = pend_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_CHECK;             // launch
            end
            ST_CHECK: begin
                if (!sup_q)         state_d = ST_IDLE;       // supply_abort
                else if (none_left) state_d = ST_IDLE;       // protect_abort
                else                state_d = ST_SEEK;       // proceed
            end
            ST_SEEK: begin
                if (scan_hit_i) state_d = ST_ERASE;          // issue
                else            state_d = ST_IDLE;           // finish
            end
            ST_ERASE: begin
                if (eng_fail_i)      state_d = ST_IDLE;      // fail_abort
                else if (eng_done_i) state_d = ST_SEEK;      // next
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // captured work list and current block
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            cur_q  <= '0;
            sup_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                pend_q <= mask_i;
                sup_q  <= supply_ok_i;
            end else if (state_q == ST_SEEK && scan_hit_i) begin
                cur_q              <= scan_idx_i;
                pend_q[scan_idx_i] <= 1'b0;
            end
        end
    end

    // registered status flags
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) flags_o <= '0;
                end
                ST_CHECK: begin
                    if (!sup_q) begin
                        flags_o[FLAG_SUPPLY] <= 1'b1;
                        flags_o[FLAG_ERASE]  <= 1'b1;
                    end else if (none_left) begin
                        flags_o[FLAG_PROTECT] <= 1'b1;
                        flags_o[FLAG_ERASE]   <= 1'b1;
                    end
                end
                ST_SEEK: ;
                ST_ERASE: begin
                    if (eng_fail_i) flags_o[FLAG_ERASE] <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // combinational outputs
    always_comb begin
        busy_o    = (state_q != ST_IDLE);
        eng_req_o = (state_q == ST_ERASE);
        eng_blk_o = cur_q;
    end

    // ---------------- assertions ----------------
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy_o && !eng_req_o && flags_o == '0));

    a_r2_launch_busy: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i) |=> busy_o);

    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (eng_req_o && !eng_done_i && !eng_fail_i) |=> (eng_req_o && $stable(eng_blk_o)));

    a_r6_req_gap: assert property (@(posedge clk) disable iff (rst)
        (eng_req_o && (eng_done_i || eng_fail_i)) |=> !eng_req_o);

    a_r7_fail_stop: assert property (@(posedge clk) disable iff (rst)
        (eng_req_o && eng_fail_i) |=> (!busy_o && flags_o[FLAG_ERASE]));

    a_r8_all_locked: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && sup_q && none_left)
            |=> (!busy_o && flags_o[FLAG_PROTECT] && flags_o[FLAG_ERASE]));

    a_r9_supply_low: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && !sup_q)
            |=> (!busy_o && flags_o[FLAG_SUPPLY] && flags_o[FLAG_ERASE] && !flags_o[FLAG_PROTECT]));

    a_r10_no_suspend: assert property (@(posedge clk) disable iff (rst)
        (eng_req_o && suspend_i && !eng_done_i && !eng_fail_i) |=> eng_req_o);

    a_r12_restart_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEEK && start_i && scan_hit_i) |=> eng_req_o);

endmodule

// File: rtl/chip_wipe_seq.sv
module chip_wipe_seq
    import wipe_pkg::*;
#(
    parameter int NBOOT  = 2,
    parameter int NPARAM = 6,
    parameter int NMAIN  = 31,
    localparam int NBLK  = NBOOT + NPARAM + NMAIN,
    localparam int IDXW  = $clog2(NBLK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [NBLK-1:0]   lock_i,
    input  logic              wp_n_i,
    input  logic              supply_ok_i,
    input  logic              suspend_i,
    output logic              eng_req_o,
    output logic [IDXW-1:0]   eng_blk_o,
    input  logic              eng_done_i,
    input  logic              eng_fail_i,
    output logic              busy_o,
    output logic [FLAG_W-1:0] flags_o
);

    logic [NBLK-1:0] mask;
    logic [NBLK-1:0] pend;
    logic [IDXW-1:0] scan_idx;
    logic            scan_hit;

    wipe_mask #(.NBOOT(NBOOT), .NBLK(NBLK)) u_mask (
        .lock_i (lock_i),
        .wp_n_i (wp_n_i),
        .mask_o (mask)
    );

    wipe_scan #(.NBLK(NBLK), .IDXW(IDXW)) u_scan (
        .pend_i (pend),
        .idx_o  (scan_idx),
        .hit_o  (scan_hit)
    );

    wipe_fsm #(.NBLK(NBLK), .IDXW(IDXW)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .supply_ok_i (supply_ok_i),
        .suspend_i   (suspend_i),
        .mask_i      (mask),
        .scan_idx_i  (scan_idx),
        .scan_hit_i  (scan_hit),
        .pend_o      (pend),
        .eng_done_i  (eng_done_i),
        .eng_fail_i  (eng_fail_i),
        .eng_req_o   (eng_req_o),
        .eng_blk_o   (eng_blk_o),
        .busy_o      (busy_o),
        .flags_o     (flags_o)
    );

endmodule

// File: tb/chip_wipe_seq_test.sv
`timescale 1ns/1ps
module chip_wipe_seq_test;

    localparam int NB = 39;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1, start = 1'b0, wp_n = 1'b1, sup_ok = 1'b1, susp = 1'b0;
    logic          done = 1'b0, fail = 1'b0;
    logic [NB-1:0] lock = '0;
    logic          req, busy;
    logic [5:0]    blk;
    logic [7:0]    flags;

    int vec = 0, bad = 0;
    int exp_q[$];
    int fail_blk = -1, lat = 1, cnt = 0;
    logic prev_req = 1'b0;

    chip_wipe_seq uut (
        .clk(clk), .rst(rst), .start_i(start), .lock_i(lock), .wp_n_i(wp_n),
        .supply_ok_i(sup_ok), .suspend_i(susp), .eng_req_o(req), .eng_blk_o(blk),
        .eng_done_i(done), .eng_fail_i(fail), .busy_o(busy), .flags_o(flags)
    );

    task automatic chk(bit ok, string tag, int act, int expv);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    // erase engine stub
    always @(negedge clk) begin
        if (done || fail) begin
            done <= 1'b0; fail <= 1'b0; cnt <= 0;
        end else if (req) begin
            if (cnt + 1 >= lat) begin
                if (int'(blk) == fail_blk) fail <= 1'b1;
                else                       done <= 1'b1;
            end
            cnt <= cnt + 1;
        end else begin
            cnt <= 0;
        end
    end

    // monitor: pops expected block indices on each new request
    always @(negedge clk) begin
        if (!rst) begin
            if (done || fail) chk(!req, "R6 request not dropped after response", int'(req), 0);
            if (req && !prev_req) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3/R4/R5 unexpected request", int'(blk), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(blk) == e, "R3/R4/R5 block order", int'(blk), e);
                end
            end
        end
        prev_req <= req;
    end

    // driver: computes the expected stream then launches
    task automatic run_case(string tag, logic [NB-1:0] lk, logic wpn, logic sup,
                            int fb, int l, logic sp, bit restart);
        int list[$];
        logic [7:0] ef;
        lock = lk; wp_n = wpn; sup_ok = sup; fail_blk = fb; lat = l; susp = sp;
        for (int i = 0; i < NB; i++)
            if (!lk[i] && !(i < 2 && !wpn)) list.push_back(i);
        ef = 8'h00;
        if (!sup) ef = 8'h28;
        else if (list.size() == 0) ef = 8'h22;
        else begin
            foreach (list[k]) begin
                exp_q.push_back(list[k]);
                if (list[k] == fb) begin ef = 8'h20; break; end
            end
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, {tag, " R2 busy after start"}, int'(busy), 1);
        chk(flags == 8'h00, {tag, " R13 flags cleared at start"}, int'(flags), 0);
        lock = ~lk;      // R13: late lock change must not matter
        if (restart) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        for (int k = 0; k < 5000; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
        chk(busy == 1'b0, {tag, " R2 busy ends"}, int'(busy), 0);
        chk(exp_q.size() == 0, {tag, " R3 all expected blocks requested"}, exp_q.size(), 0);
        chk(flags == ef, {tag, " R7/R8/R9 final flags"}, int'(flags), int'(ef));
        chk(req == 1'b0, {tag, " R6 no request when idle"}, int'(req), 0);
        exp_q.delete();
        susp = 1'b0;
        repeat (3) @(negedge clk);
        chk(req == 1'b0, {tag, " R6 no late request"}, int'(req), 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    endtask

    initial begin
        #600000;
        bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && req == 1'b0 && flags == 8'h00, "R1 reset state",
            int'({busy, req, flags}), 0);
        rst = 1'b0;
        @(negedge clk);

        run_case("R3 all free",        '0, 1'b1, 1'b1, -1, 1, 1'b0, 1'b0);
        run_case("R5 wp low",          '0, 1'b0, 1'b1, -1, 2, 1'b0, 1'b0);
        run_case("R4 alternating",     39'h55_5555_5555, 1'b1, 1'b1, -1, 3, 1'b0, 1'b0);
        run_case("R5 boot only prot",  ~39'h3, 1'b0, 1'b1, -1, 1, 1'b0, 1'b0);
        run_case("R8 all locked",      '1, 1'b1, 1'b1, -1, 1, 1'b0, 1'b0);
        run_case("R9 supply low",      '0, 1'b1, 1'b0, -1, 1, 1'b0, 1'b0);
        run_case("R9 supply+locked",   '1, 1'b1, 1'b0, -1, 1, 1'b0, 1'b0);
        run_case("R7 fail mid",        '0, 1'b1, 1'b1, 10, 2, 1'b0, 1'b0);
        run_case("R7 fail first",      '0, 1'b1, 1'b1, 0, 1, 1'b0, 1'b0);
        run_case("R10 suspend held",   39'h0A_0F00_F0F3, 1'b1, 1'b1, -1, 2, 1'b1, 1'b0);
        run_case("R12 restart mid",    '0, 1'b1, 1'b1, -1, 2, 1'b0, 1'b1);
        run_case("R5 top only",        {1'b0, {38{1'b1}}}, 1'b0, 1'b1, -1, 1, 1'b0, 1'b0);

        // R11: reset in the middle of a run
        lock = '0; wp_n = 1'b1; sup_ok = 1'b1; fail_blk = -1; lat = 2;
        for (int i = 0; i < NB; i++) exp_q.push_back(i);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R11 busy cleared by reset", int'(busy), 0);
        chk(req == 1'b0, "R11 request cleared by reset", int'(req), 0);
        chk(flags == 8'h00, "R1 flags after reset", int'(flags), 0);
        exp_q.delete();
        rst = 1'b0;
        repeat (2) @(negedge clk);
        run_case("R11 recover",        '0, 1'b1, 1'b1, -1, 1, 1'b0, 1'b0);

        finish_run();
    end

endmodule